// File: doc/BRIEF.md
# Instruction Overlap Eligibility Controller

This block sits beside the instruction fetch path of a processor that runs code out of a page memory. Each instruction can ask for its successor to be fetched while it is still executing. The request is a two-bit code carried in the lowest bits of the instruction word. For every instruction the controller decides whether that request may be honoured. The decision uses the already-decoded class of the current instruction, the class of the instruction that follows it, and whether execution is currently from page memory.

The controller reports three things one clock after each instruction strobe: whether overlapped fetch is enabled, whether the request was an illegal marking, and how many cycles the current instruction saves. An illegal marking also sets an error flag that stays set until reset. A load-immediate instruction that is granted overlap does not get shorter itself. Its saving is passed on to the next instruction in the stream.

Top module: `overlap_ctl`

## Requirements
- R1: A request is present only when instruction bit 1 is 1 and bit 0 is 0 (`instr_code` = 2'b10). The codes 2'b00, 2'b01 and 2'b11 never grant overlap and never flag an error.
- R2: When `from_page` is 0, a request is ignored. That instruction reports no overlap, no error and a saving of 0.
- R3: Class codes are 0 array memory, 1 array register, 2 load immediate, 3 control register without memory reference. Codes 4 to 11 are the forbidden kinds: external function, branch, load immediate to status word, swap status word, control register load, control register store, loop and general register. Codes 12 to 15 are reserved. A request from page memory is granted (`overlap_en` = 1) when both `cur_class` and `next_class` are in 0..3.
- R4: A request from page memory with `cur_class` outside 0..3 is illegal. The result shows `err_now` = 1 and `overlap_en` = 0.
- R5: A request from page memory with `next_class` outside 0..3 is illegal, even when `cur_class` is allowed. This covers an instruction placed just before a forbidden kind.
- R6: A granted instruction that is not a load immediate reports a saving of at least 1 cycle in `cycle_save`.
- R7: A granted load immediate adds nothing to its own `cycle_save`. The next strobed instruction, if it is from page memory, gets +1 added to its `cycle_save`, so the value can reach 2.
- R8: `err_sticky` is set by the first illegal request and stays 1 until reset.
- R9: Results appear exactly one clock after a strobe, with `out_valid` = 1. On cycles without a strobe, `out_valid`, `overlap_en`, `err_now` and `cycle_save` are 0, and a pending inherited saving is kept for the next strobe. After reset every output is 0.
- R10: A pending inherited saving is used up by the very next strobe. If that strobe is not from page memory, the saving is dropped and is not carried any further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Strobe: one instruction presented this cycle |
| instr_code | input | 2 | Bits 1:0 of the instruction word (overlap request code) |
| cur_class | input | 4 | Decoded class of the current instruction |
| next_class | input | 4 | Decoded class of the following instruction |
| from_page | input | 1 | Execution is from page memory |
| out_valid | output | 1 | Result for the previous cycle's strobe |
| overlap_en | output | 1 | Overlapped fetch granted |
| cycle_save | output | 2 | Cycles saved by this instruction (0..2) |
| err_now | output | 1 | This instruction carried an illegal request |
| err_sticky | output | 1 | An illegal request has occurred since reset |

## Verification
The bench sweeps every pair of current and next classes under the request code. A design that checks only the current class would grant overlap in front of a branch or loop, and the R5 pair sweep exposes this at once. Load-immediate chains are tested with idle gaps between strobes and with an off-page strobe placed after a granted load immediate. A design that clears its pending saving on idle cycles, or that carries the saving past the off-page instruction, reports a wrong `cycle_save`. The other two request codes, sticky error persistence and reset clearing are also driven. A long random stream is then compared on every clock against a behavioural model.

// File: rtl/overlap_pkg.sv
// Shared definitions for the instruction overlap eligibility controller.
// Assumes class codes are produced by an upstream decoder in this encoding.
package overlap_pkg;

    localparam int CLASS_W   = 4;
    localparam int CODE_W    = 2;
    localparam int SAVE_W    = 2;
    localparam int N_LOOKUP  = 2;   // current and next class filters

    // Request code: bit 1 set, bit 0 clear.
    localparam logic [CODE_W-1:0] REQ_CODE = 2'b10;

    typedef enum logic [CLASS_W-1:0] {
        CLS_ARR_MEM    = 4'd0,
        CLS_ARR_REG    = 4'd1,
        CLS_LOAD_IMM   = 4'd2,
        CLS_CREG_LOCAL = 4'd3,
        CLS_EXT_FUNC   = 4'd4,
        CLS_BRANCH     = 4'd5,
        CLS_LDI_STATUS = 4'd6,
        CLS_SWAP_STAT  = 4'd7,
        CLS_CREG_LOAD  = 4'd8,
        CLS_CREG_STORE = 4'd9,
        CLS_LOOP       = 4'd10,
        CLS_GREG       = 4'd11
    } ovl_class_e;

    // Highest code of the allowed group; allowed classes are 0..ALLOW_MAX.
    localparam logic [CLASS_W-1:0] ALLOW_MAX = 4'd3;

endpackage

// File: rtl/ovl_code_detect.sv
// Detects the overlap request code in the low instruction bits.
// Assumes the code field is already extracted from the instruction word.
module ovl_code_detect
    import overlap_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic              req
);
    // Compare the code field against the single request pattern.
    always_comb begin
        req = (code == REQ_CODE);
    end
endmodule

// File: rtl/ovl_class_filter.sv
// Tells whether a decoded class may carry, or may follow, an overlap request.
// Assumes reserved codes are never allowed.
module ovl_class_filter
    import overlap_pkg::*;
(
    input  logic [CLASS_W-1:0] cls,
    output logic               allowed
);
    // Allowed group occupies the lowest codes.
    always_comb begin
        allowed = (cls <= ALLOW_MAX);
    end
endmodule

// File: rtl/ovl_save_track.sv
// Computes the per-instruction cycle saving and carries the saving that a
// granted load immediate hands to its successor.
// Assumes grant is already qualified by the strobe and page source.
module ovl_save_track
    import overlap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              from_page,
    input  logic              grant,
    input  logic              cur_is_ldi,
    output logic [SAVE_W-1:0] cycle_save
);
    logic              pend_q;
    logic [SAVE_W-1:0] own_save;
    logic [SAVE_W-1:0] inh_save;

    // Own and inherited contributions for the instruction now strobed.
    always_comb begin
        own_save = (grant && !cur_is_ldi) ? SAVE_W'(1) : '0;
        inh_save = (strobe && from_page && pend_q) ? SAVE_W'(1) : '0;
    end

    // Pending inherited saving: set by a granted load immediate, consumed by the next strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (strobe) begin
            pend_q <= grant && cur_is_ldi;
        end
    end

    // Registered saving result, zero on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycle_save <= '0;
        end else if (strobe) begin
            cycle_save <= own_save + inh_save;
        end else begin
            cycle_save <= '0;
        end
    end
endmodule

// File: rtl/overlap_ctl.sv
// Instruction overlap eligibility controller. For each strobed instruction it
// grants or refuses overlapped fetch, flags illegal requests and reports the
// cycle saving. Assumes classes arrive decoded and the next class is known
// when the current instruction is strobed.
module overlap_ctl
    import overlap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [CODE_W-1:0]  instr_code,
    input  logic [CLASS_W-1:0] cur_class,
    input  logic [CLASS_W-1:0] next_class,
    input  logic               from_page,
    output logic               out_valid,
    output logic               overlap_en,
    output logic [SAVE_W-1:0]  cycle_save,
    output logic               err_now,
    output logic               err_sticky
);
    logic                req;
    logic [CLASS_W-1:0]  cls_arr [N_LOOKUP];
    logic [N_LOOKUP-1:0] allow_v;
    logic                active;
    logic                grant;
    logic                bad;
    logic                cur_is_ldi;

    ovl_code_detect u_code (
        .code (instr_code),
        .req  (req)
    );

    // Route current and next class into the lookup array.
    always_comb begin
        cls_arr[0] = cur_class;
        cls_arr[1] = next_class;
    end

    for (genvar i = 0; i < N_LOOKUP; i++) begin : g_filter
        ovl_class_filter u_filter (
            .cls     (cls_arr[i]),
            .allowed (allow_v[i])
        );
    end

    // Qualify the request and split it into grant or illegal.
    always_comb begin
        active     = instr_valid && from_page && req;
        grant      = active && (&allow_v);
        bad        = active && !(&allow_v);
        cur_is_ldi = (cur_class == CLS_LOAD_IMM);
    end

    ovl_save_track u_save (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (instr_valid),
        .from_page  (from_page),
        .grant      (grant),
        .cur_is_ldi (cur_is_ldi),
        .cycle_save (cycle_save)
    );

    // Registered per-instruction result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            overlap_en <= 1'b0;
            err_now    <= 1'b0;
        end else begin
            out_valid  <= instr_valid;
            overlap_en <= grant;
            err_now    <= bad;
        end
    end

    // Sticky error, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_sticky <= 1'b0;
        end else if (bad) begin
            err_sticky <= 1'b1;
        end
    end
endmodule

// File: rtl/overlap_ctl_chk.sv
// Property checker for overlap_ctl, attached by bind.
module overlap_ctl_chk
    import overlap_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               instr_valid,
    input logic [CODE_W-1:0]  instr_code,
    input logic [CLASS_W-1:0] cur_class,
    input logic [CLASS_W-1:0] next_class,
    input logic               from_page,
    input logic               out_valid,
    input logic               overlap_en,
    input logic [SAVE_W-1:0]  cycle_save,
    input logic               err_now,
    input logic               err_sticky
);
    a_r1_no_code_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_code != 2'b10) |=> (!overlap_en && !err_now));

    a_r2_off_page_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !from_page) |=> (!overlap_en && !err_now && cycle_save == 2'd0));

    a_r4_err_blocks_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        err_now |-> !overlap_en);

    a_r6_grant_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && from_page && instr_code == 2'b10 && cur_class <= 4'd3 &&
         next_class <= 4'd3 && cur_class != 4'd2) |=> (overlap_en && cycle_save != 2'd0));

    a_r7_ldi_not_shortened: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && cur_class == 4'd2) |=> (cycle_save <= 2'd1));

    a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    a_r8_err_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_now |-> err_sticky);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!out_valid && !overlap_en && !err_now && cycle_save == 2'd0));
endmodule

bind overlap_ctl overlap_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_code  (instr_code),
    .cur_class   (cur_class),
    .next_class  (next_class),
    .from_page   (from_page),
    .out_valid   (out_valid),
    .overlap_en  (overlap_en),
    .cycle_save  (cycle_save),
    .err_now     (err_now),
    .err_sticky  (err_sticky)
);

// File: tb/overlap_ctl_bench.sv
// Bench for overlap_ctl: behavioural reference model compared every clock.
module overlap_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic [1:0] instr_code = 2'b00;
    logic [3:0] cur_class = 4'd0;
    logic [3:0] next_class = 4'd0;
    logic       from_page = 1'b0;
    logic       out_valid, overlap_en, err_now, err_sticky;
    logic [1:0] cycle_save;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string ctx     = "R9";

    // Reference model state
    int e_valid = 0, e_ovl = 0, e_save = 0, e_err = 0, e_stk = 0, m_pend = 0;

    always #5 clk = ~clk;

    overlap_ctl u_overlap_ctl (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_code(instr_code),
        .cur_class(cur_class), .next_class(next_class), .from_page(from_page),
        .out_valid(out_valid), .overlap_en(overlap_en), .cycle_save(cycle_save),
        .err_now(err_now), .err_sticky(err_sticky)
    );

    function automatic bit ok_class(input int c);
        return c >= 0 && c <= 3;
    endfunction

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            e_valid = 0; e_ovl = 0; e_save = 0; e_err = 0; e_stk = 0; m_pend = 0;
        end else if (instr_valid) begin
            bit want, g, b;
            want = (instr_code == 2'b10) && from_page;
            g = want && ok_class(cur_class) && ok_class(next_class);
            b = want && !g;
            e_valid = 1;
            e_ovl   = g;
            e_err   = b;
            if (b) e_stk = 1;
            e_save  = ((g && cur_class != 4'd2) ? 1 : 0) + ((m_pend && from_page) ? 1 : 0);
            m_pend  = g && (cur_class == 4'd2);
        end else begin
            e_valid = 0; e_ovl = 0; e_save = 0; e_err = 0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (%s) %s: actual %0d expected %0d at %0t", req, ctx, what, act, exp, $time);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk("R9", "out_valid",  out_valid,  e_valid);
            chk("R3", "overlap_en", overlap_en, e_ovl);
            chk("R6", "cycle_save", cycle_save, e_save);
            chk("R4", "err_now",    err_now,    e_err);
            chk("R8", "err_sticky", err_sticky, e_stk);
        end
    end

    task automatic put(input bit v, input logic [1:0] code, input int cc, input int nc, input bit pg);
        @(negedge clk);
        instr_valid = v; instr_code = code;
        cur_class = 4'(cc); next_class = 4'(nc); from_page = pg;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(0, 2'b00, 0, 0, 1);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; instr_valid = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        ctx = "R9 reset";
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle(2);

        ctx = "R1 codes";
        put(1, 2'b00, 0, 1, 1); put(1, 2'b01, 0, 1, 1);
        put(1, 2'b11, 4, 5, 1); put(1, 2'b10, 0, 1, 1);
        idle(1);

        ctx = "R3 R6 allowed pairs";
        for (int c = 0; c < 4; c++)
            for (int n = 0; n < 4; n++) put(1, 2'b10, c, n, 1);
        idle(2);

        ctx = "R2 off page";
        put(1, 2'b10, 0, 0, 0); put(1, 2'b10, 5, 10, 0);
        idle(1);

        ctx = "R7 load immediate chain";
        put(1, 2'b10, 2, 0, 1); put(1, 2'b00, 0, 5, 1);
        put(1, 2'b10, 2, 1, 1); idle(3); put(1, 2'b10, 1, 3, 1);
        put(1, 2'b10, 2, 2, 1); put(1, 2'b10, 2, 0, 1); put(1, 2'b10, 0, 0, 1);
        idle(1);

        ctx = "R10 dropped saving";
        put(1, 2'b10, 2, 0, 1); put(1, 2'b10, 0, 0, 0); put(1, 2'b00, 1, 1, 1);
        idle(1);

        ctx = "R4 forbidden current";
        do_reset();
        for (int c = 4; c < 16; c++) put(1, 2'b10, c, 0, 1);
        idle(1);

        ctx = "R5 forbidden next";
        for (int n = 4; n < 16; n++) put(1, 2'b10, 1, n, 1);
        idle(1);

        ctx = "R8 sticky";
        put(1, 2'b10, 0, 0, 1); idle(4);
        do_reset(); idle(1);

        ctx = "random";
        for (int i = 0; i < 3000; i++) begin
            if (i % 700 == 699) do_reset();
            put(($urandom % 4) != 0, 2'($urandom), $urandom % 16, $urandom % 16, ($urandom % 5) != 0);
        end
        idle(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule